// File: doc/BRIEF.md
# Paired-Axis Traffic Light Sequencer

This block controls the signal heads of a four-way crossing in which the two approaches on each axis are paired: north and south always show one lamp set, and east and west always show another. The sequencer moves through four phases in a fixed ring. North-south goes green, then yellow, while east-west holds red. Then east-west goes green, then yellow, while north-south holds red. It then returns to the first phase.

Elapsed time comes in on a one-clock tick enable that the surrounding chip asserts once per second. Two interval timers count these ticks down. A long timer times each green phase and a short timer times each yellow phase. The phase logic starts the matching timer when it enters a phase. The timer's alarm tells the phase logic to move on. The lamp decode turns the phase into one green, yellow or red signal for each axis.

Top module: `tl_sequencer`

## Requirements
- R1: While reset is high, and on the first cycle after it, the outputs show north-south green and east-west red. Reset starts the long timer with its full interval.
- R2: The phases follow the ring NS-green, NS-yellow, EW-green, EW-yellow, then back to NS-green. No phase is skipped. The phase encoding is 0, 1, 2, 3 in that order.
- R3: A green phase counts exactly LONG_TICKS tick pulses, default 45. A tick is counted when it is high at a clock edge that does not change the phase.
- R4: A yellow phase counts exactly SHORT_TICKS tick pulses, default 15, under the same counting rule as R3.
- R5: Exactly one of green, yellow and red is high on each axis in every cycle.
- R6: At least one axis shows red in every cycle, so the two axes are never green or yellow together.
- R7: The phase changes only on the clock edge that follows the edge at which the final tick was counted. A tick that is high at that changing edge is ignored. It counts toward neither the old phase nor the new one.
- R8: Reset asserted in the middle of the ring returns the block to NS-green with a fresh, full green interval.
- R9: While tick stays low, the lamps do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-clock pulse marking one second |
| ns_green | output | 1 | North-south green lamp |
| ns_yellow | output | 1 | North-south yellow lamp |
| ns_red | output | 1 | North-south red lamp |
| ew_green | output | 1 | East-west green lamp |
| ew_yellow | output | 1 | East-west yellow lamp |
| ew_red | output | 1 | East-west red lamp |

## Verification
The bench keeps its own count of ticks for each phase and drives several tick patterns: sparse periodic ticks, a tick held high on every cycle, a random tick stream, and long gaps with no tick. If a tick at the phase-change edge were counted, or the timer were reloaded one cycle late, every phase would come out one tick short or long. A timer that ignored a reload would carry ticks over from the previous phase. Reset is also applied in the middle of an east-west green. A design that kept its old timer contents there would leave the first green after reset short. A decode with a crossed axis would light two greens at once, and the per-cycle safety check would catch it.

// File: rtl/tl_pkg.sv
package tl_pkg;

    typedef enum logic [1:0] {
        PH_NS_GO   = 2'd0,
        PH_NS_WARN = 2'd1,
        PH_EW_GO   = 2'd2,
        PH_EW_WARN = 2'd3
    } phase_e;

    typedef struct packed {
        logic green;
        logic yellow;
        logic red;
    } lamp_t;

    localparam int NUM_AXES = 2;
    localparam int AXIS_NS  = 0;
    localparam int AXIS_EW  = 1;

    function automatic logic phase_is_go(input phase_e p);
        return (p == PH_NS_GO) || (p == PH_EW_GO);
    endfunction

    function automatic lamp_t axis_lamp(input phase_e p, input int axis);
        lamp_t l;
        l = '{green: 1'b0, yellow: 1'b0, red: 1'b1};
        if (axis == AXIS_NS) begin
            if (p == PH_NS_GO)   l = '{green: 1'b1, yellow: 1'b0, red: 1'b0};
            if (p == PH_NS_WARN) l = '{green: 1'b0, yellow: 1'b1, red: 1'b0};
        end else begin
            if (p == PH_EW_GO)   l = '{green: 1'b1, yellow: 1'b0, red: 1'b0};
            if (p == PH_EW_WARN) l = '{green: 1'b0, yellow: 1'b1, red: 1'b0};
        end
        return l;
    endfunction

endpackage

// File: rtl/tl_interval_timer.sv
module tl_interval_timer #(
    parameter int INTERVAL       = 45,
    parameter bit START_ON_RESET = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic start,
    output logic alarm
);
    localparam int CNT_W = $clog2(INTERVAL + 1);

    logic [CNT_W-1:0] remaining;

    always_ff @(posedge clk) begin
        if (rst) begin
            remaining <= START_ON_RESET ? CNT_W'(INTERVAL) : '0;
            alarm     <= 1'b0;
        end else if (start) begin
            remaining <= CNT_W'(INTERVAL);
            alarm     <= 1'b0;
        end else if (tick && (remaining != '0)) begin
            remaining <= remaining - 1'b1;
            alarm     <= (remaining == CNT_W'(1));
        end else begin
            alarm     <= 1'b0;
        end
    end

    // an alarm follows a counted tick and lasts one cycle (R3, R4)
    p_alarm_after_tick_r3: assert property (@(posedge clk) disable iff (rst)
        alarm |-> ($past(tick) && !$past(start)));
    p_alarm_single_r4: assert property (@(posedge clk) disable iff (rst)
        alarm |=> !alarm);

endmodule

// File: rtl/tl_phase_fsm.sv
module tl_phase_fsm
    import tl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   long_alarm,
    input  logic   short_alarm,
    output phase_e phase,
    output logic   start_long,
    output logic   start_short
);
    phase_e phase_q;
    phase_e phase_nxt;
    logic   due;

    assign due = phase_is_go(phase_q) ? long_alarm : short_alarm;

    always_comb begin
        case (phase_q)
            PH_NS_GO:   phase_nxt = PH_NS_WARN;
            PH_NS_WARN: phase_nxt = PH_EW_GO;
            PH_EW_GO:   phase_nxt = PH_EW_WARN;
            PH_EW_WARN: phase_nxt = PH_NS_GO;
            default:    phase_nxt = PH_NS_GO;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)      phase_q <= PH_NS_GO;
        else if (due) phase_q <= phase_nxt;
    end

    // timer start issued on the same edge that enters the new phase
    assign start_long  = due &&  phase_is_go(phase_nxt);
    assign start_short = due && !phase_is_go(phase_nxt);
    assign phase       = phase_q;

    p_seq_order_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (phase_q != $past(phase_q)))
            |-> (2'(phase_q) == 2'(2'($past(phase_q)) + 2'd1)));
    p_move_on_alarm_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (phase_q != $past(phase_q))) |-> $past(due));

endmodule

// File: rtl/tl_lamp_decode.sv
module tl_lamp_decode
    import tl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_e phase,
    output lamp_t  lamps [NUM_AXES]
);
    for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
        assign lamps[a] = axis_lamp(phase, a);

        p_axis_onehot_r5: assert property (@(posedge clk) disable iff (rst)
            $countones(lamps[a]) == 1);
    end

    p_cross_safe_r6: assert property (@(posedge clk) disable iff (rst)
        lamps[AXIS_NS].red || lamps[AXIS_EW].red);

endmodule

// File: rtl/tl_sequencer.sv
module tl_sequencer
    import tl_pkg::*;
#(
    parameter int LONG_TICKS  = 45,
    parameter int SHORT_TICKS = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic ns_green,
    output logic ns_yellow,
    output logic ns_red,
    output logic ew_green,
    output logic ew_yellow,
    output logic ew_red
);
    logic   long_alarm, short_alarm;
    logic   start_long, start_short;
    phase_e phase;
    lamp_t  lamps [NUM_AXES];

    tl_interval_timer #(.INTERVAL(LONG_TICKS), .START_ON_RESET(1'b1)) u_long_tmr (
        .clk(clk), .rst(rst), .tick(tick), .start(start_long), .alarm(long_alarm)
    );

    tl_interval_timer #(.INTERVAL(SHORT_TICKS), .START_ON_RESET(1'b0)) u_short_tmr (
        .clk(clk), .rst(rst), .tick(tick), .start(start_short), .alarm(short_alarm)
    );

    tl_phase_fsm u_fsm (
        .clk(clk), .rst(rst),
        .long_alarm(long_alarm), .short_alarm(short_alarm),
        .phase(phase), .start_long(start_long), .start_short(start_short)
    );

    tl_lamp_decode u_decode (
        .clk(clk), .rst(rst), .phase(phase), .lamps(lamps)
    );

    assign ns_green  = lamps[AXIS_NS].green;
    assign ns_yellow = lamps[AXIS_NS].yellow;
    assign ns_red    = lamps[AXIS_NS].red;
    assign ew_green  = lamps[AXIS_EW].green;
    assign ew_yellow = lamps[AXIS_EW].yellow;
    assign ew_red    = lamps[AXIS_EW].red;

endmodule

// File: tb/test_tl_sequencer.sv
module test_tl_sequencer;
    localparam int LONG  = 45;
    localparam int SHORT = 15;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic ns_green, ns_yellow, ns_red, ew_green, ew_yellow, ew_red;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // behavioural reference state
    int m_phase = 0;
    int m_left  = LONG;
    bit m_due   = 1'b0;
    bit last_tick = 1'b0;
    bit last_rst  = 1'b1;

    // interval bookkeeping from observed outputs
    int obs_prev = 0;
    int tick_cnt = 0;
    bit cnt_valid = 1'b0;

    always #4 clk = ~clk;

    tl_sequencer #(.LONG_TICKS(LONG), .SHORT_TICKS(SHORT)) i_tl_sequencer (
        .clk(clk), .rst(rst), .tick(tick),
        .ns_green(ns_green), .ns_yellow(ns_yellow), .ns_red(ns_red),
        .ew_green(ew_green), .ew_yellow(ew_yellow), .ew_red(ew_red)
    );

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        last_tick = tick && !rst;
        last_rst  = rst;
        if (rst) begin
            m_phase = 0; m_left = LONG; m_due = 1'b0;
        end else if (m_due) begin
            m_phase = (m_phase + 1) % 4;
            m_left  = (m_phase % 2 == 0) ? LONG : SHORT;
            m_due   = 1'b0;
        end else if (tick && m_left > 0) begin
            m_left--;
            if (m_left == 0) m_due = 1'b1;
        end
        if (cyc > 100000) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not end, actual cycle %0d expected below 100000", cyc);
            finish_run();
        end
    end

    function automatic int obs_phase();
        if (ns_green)  return 0;
        if (ns_yellow) return 1;
        if (ew_green)  return 2;
        if (ew_yellow) return 3;
        return -1;
    endfunction

    always @(negedge clk) begin
        logic [5:0] act, exp;
        int ph;
        exp = {m_phase == 0, m_phase == 1, m_phase > 1,
               m_phase == 2, m_phase == 3, m_phase < 2};
        act = {ns_green, ns_yellow, ns_red, ew_green, ew_yellow, ew_red};
        checks++;
        if (act !== exp) begin
            fails++;
            if (last_rst) $display("FAIL R1 reset lamps: actual %b expected %b", act, exp);
            else $display("FAIL R2/R7 lamps: actual %b expected %b", act, exp);
        end
        checks++;
        if (!(ns_red || ew_red)) begin
            fails++;
            $display("FAIL R6 both axes non-red: actual %b expected some red", act);
        end
        checks++;
        if ($countones(act[5:3]) != 1 || $countones(act[2:0]) != 1) begin
            fails++;
            $display("FAIL R5 per-axis one-hot: actual %b expected one lamp per axis", act);
        end
        ph = obs_phase();
        if (last_rst) begin
            tick_cnt = 0; cnt_valid = 1'b1; obs_prev = ph;
        end else if (ph != obs_prev) begin
            if (cnt_valid) begin
                checks++;
                if (tick_cnt != ((obs_prev % 2 == 0) ? LONG : SHORT)) begin
                    fails++;
                    if (obs_prev % 2 == 0)
                        $display("FAIL R3 green ticks: actual %0d expected %0d", tick_cnt, LONG);
                    else
                        $display("FAIL R4 yellow ticks: actual %0d expected %0d", tick_cnt, SHORT);
                end
            end
            tick_cnt = 0; cnt_valid = 1'b1; obs_prev = ph;
        end else begin
            tick_cnt += int'(last_tick);
        end
    end

    initial begin
        logic [31:0] lf;
        logic [5:0] held;
        lf = 32'h1234_5678;
        repeat (5) @(negedge clk);
        // R1: explicit reset-state check
        checks++;
        if (!(ns_green && ew_red)) begin
            fails++;
            $display("FAIL R1 reset: actual ns_g=%b ew_r=%b expected 1 1", ns_green, ew_red);
        end
        rst = 1'b0;
        // sparse periodic ticks (R2, R3, R4)
        for (int i = 0; i < 2000; i++) begin
            tick = (i % 4 == 3);
            @(negedge clk);
        end
        // tick high every cycle, including phase-change edges (R7)
        for (int i = 0; i < 300; i++) begin
            tick = 1'b1;
            @(negedge clk);
        end
        // no ticks: lamps must hold (R9)
        tick = 1'b0;
        @(negedge clk);
        held = {ns_green, ns_yellow, ns_red, ew_green, ew_yellow, ew_red};
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            checks++;
            if ({ns_green, ns_yellow, ns_red, ew_green, ew_yellow, ew_red} !== held) begin
                fails++;
                $display("FAIL R9 hold without tick: actual %b expected %b",
                         {ns_green, ns_yellow, ns_red, ew_green, ew_yellow, ew_red}, held);
            end
        end
        // run into EW green, then reset mid-ring (R8)
        for (int i = 0; i < 2000; i++) begin
            if (ew_green) break;
            tick = (i % 3 == 0);
            @(negedge clk);
        end
        repeat (7) begin
            tick = ~tick;
            @(negedge clk);
        end
        rst = 1'b1;
        tick = 1'b1;
        @(negedge clk);
        checks++;
        if (!(ns_green && ew_red)) begin
            fails++;
            $display("FAIL R8 mid-ring reset: actual ns_g=%b ew_r=%b expected 1 1", ns_green, ew_red);
        end
        @(negedge clk);
        rst = 1'b0;
        // random tick stream
        for (int i = 0; i < 4000; i++) begin
            lf = lf * 32'd1103515245 + 32'd12345;
            tick = lf[16];
            @(negedge clk);
        end
        tick = 1'b0;
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule